// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block passes an 18-bit word between an A side and a B side. It has one storage element for each direction, so A-to-B and B-to-A work independently. Each storage element is chosen at run time to work as a transparent latch or as an edge-captured register. The choice is made by that direction's latch enable. The direction's transceiver clock has an active-low clock enable that gates it. An active-low output enable controls whether the receiving side is driven. Each bus side is modelled as separate input, output and drive-enable signals. There are no inout pins.

The model is synchronous to a fast system clock `clk_i`. Latch enable and clock enable are sampled on each system clock edge. A transceiver clock rising edge is detected by comparing the clock's current level with its level at the previous system edge. When a direction is transparent, its output follows its input combinationally.

Top module: `bus_xcvr`

## Requirements
- R1: While a direction's latch enable is high and its output enable is low, that direction's output equals its input in the same cycle.
- R2: While latch enable is low and no rising transceiver-clock edge is detected, the stored word does not change.
- R3: With latch enable low, a rising transceiver-clock edge while clock enable (active low) is 0 stores the input word present at that system edge.
- R4: With latch enable low, a rising transceiver-clock edge while clock enable is 1 leaves the stored word unchanged.
- R5: While latch enable is high, the stored word follows the input at every system edge, whatever the clock and clock-enable levels are.
- R6: When latch enable falls, the last word seen in transparent mode is kept until the next enabled rising edge.
- R7: A side's drive-enable output equals the inverse of its output-enable input. While not driven, that side's data output is all zeros.
- R8: The B-to-A direction has the same behaviour as A-to-B and does not depend on any A-to-B control.
- R9: Reset (`rst_ni` low, asynchronous) clears both stored words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the controls |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | A-side input word |
| b_i | input | 18 | B-side input word |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B transceiver clock |
| ab_ce_ni | input | 1 | A-to-B clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A transceiver clock |
| ba_ce_ni | input | 1 | B-to-A clock enable, active low |
| a_o | output | 18 | Word driven onto the A side |
| a_oe_o | output | 1 | A-side drive enable |
| b_o | output | 18 | Word driven onto the B side |
| b_oe_o | output | 1 | B-side drive enable |

## Verification
The assertions assume that the transceiver clock inputs change no faster than the system clock. Every level is assumed to be held for at least one system cycle, so a rising edge shows up as one low sample followed by one high sample. The bench changes inputs only on falling system edges, so every transceiver clock level lasts a full system cycle. The stimulus sweeps every ordered pair of the four control bits in each direction, so every mode-to-mode transition appears in both directions.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned XCVR_W = 18;
  localparam int unsigned N_DIR  = 2;
  typedef enum logic [0:0] {DIR_AB = 1'b0, DIR_BA = 1'b1} dir_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         xclk_i,
  input  logic         ce_ni,
  input  logic         oe_ni,
  output logic [W-1:0] q_o,
  output logic         en_o
);
  logic         rise;
  logic [W-1:0] store_q;
  logic [W-1:0] pass;

  xcvr_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (xclk_i),
    .rise_o(rise)
  );

  // latch enable outranks the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               store_q <= '0;
    else if (le_i)             store_q <= d_i;
    else if (rise && !ce_ni)   store_q <= d_i;
  end

  assign pass = le_i ? d_i : store_q;
  assign en_o = ~oe_ni;
  assign q_o  = en_o ? pass : '0;

  p_trans_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !oe_ni) |-> (q_o == d_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise) |=> $stable(store_q));
  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise && !ce_ni) |=> (store_q == $past(d_i)));
  p_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise && ce_ni) |=> $stable(store_q));
  p_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (store_q == $past(d_i)));
  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (q_o == '0 && !en_o));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_clk_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_clk_i,
  input  logic         ba_ce_ni,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [N_DIR-1:0][W-1:0] din, dout;
  logic [N_DIR-1:0]        le, xclk, ce_n, oe_n, en;

  assign din[DIR_AB]  = a_i;      assign din[DIR_BA]  = b_i;
  assign le[DIR_AB]   = ab_le_i;  assign le[DIR_BA]   = ba_le_i;
  assign xclk[DIR_AB] = ab_clk_i; assign xclk[DIR_BA] = ba_clk_i;
  assign ce_n[DIR_AB] = ab_ce_ni; assign ce_n[DIR_BA] = ba_ce_ni;
  assign oe_n[DIR_AB] = ab_oe_ni; assign oe_n[DIR_BA] = ba_oe_ni;

  // R8: one identical, independent cell per direction
  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    xcvr_cell #(.W(W)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (din[g]),
      .le_i  (le[g]),
      .xclk_i(xclk[g]),
      .ce_ni (ce_n[g]),
      .oe_ni (oe_n[g]),
      .q_o   (dout[g]),
      .en_o  (en[g])
    );
  end

  assign b_o    = dout[DIR_AB];
  assign b_oe_o = en[DIR_AB];
  assign a_o    = dout[DIR_BA];
  assign a_oe_o = en[DIR_BA];
endmodule

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
  localparam int W = 18;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_clk = 1'b0, ab_ce_n = 1'b1;
  logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_clk = 1'b0, ba_ce_n = 1'b1;
  logic a_oe, b_oe;

  int checks = 0, errors = 0;
  logic [W-1:0] ref_ab = '0, ref_ba = '0;
  logic prev_ab = 1'b0, prev_ba = 1'b0;
  string tag_ab, tag_ba;

  always #(PERIOD/2) clk = ~clk;

  bus_xcvr dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in),
    .ab_oe_ni(ab_oe_n), .ab_le_i(ab_le), .ab_clk_i(ab_clk), .ab_ce_ni(ab_ce_n),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_clk_i(ba_clk), .ba_ce_ni(ba_ce_n),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // reference update from the requirements, using the values driven before the edge
  task automatic model_edge();
    if (ab_le) begin ref_ab = a_in; tag_ab = "R5"; end
    else if (ab_clk && !prev_ab && !ab_ce_n) begin ref_ab = a_in; tag_ab = "R3"; end
    else if (ab_clk && !prev_ab) tag_ab = "R4";
    else tag_ab = "R2";
    if (ba_le) begin ref_ba = b_in; tag_ba = "R8 R5"; end
    else if (ba_clk && !prev_ba && !ba_ce_n) begin ref_ba = b_in; tag_ba = "R8 R3"; end
    else if (ba_clk && !prev_ba) tag_ba = "R8 R4";
    else tag_ba = "R8 R2";
    prev_ab = ab_clk;
    prev_ba = ba_clk;
  endtask

  task automatic check_outputs();
    string t;
    chk("R7 b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, ~ab_oe_n});
    chk("R8 R7 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~ba_oe_n});
    t = ab_oe_n ? "R7" : (ab_le ? "R1" : tag_ab);
    chk(t, b_out, ab_oe_n ? '0 : (ab_le ? a_in : ref_ab));
    t = ba_oe_n ? "R8 R7" : (ba_le ? "R8 R1" : tag_ba);
    chk(t, a_out, ba_oe_n ? '0 : (ba_le ? b_in : ref_ba));
  endtask

  // called at a falling edge; code bits: [3]=le [2]=clk [1]=ce_n [0]=oe_n
  task automatic step(logic [3:0] ab, logic [3:0] ba, logic [W-1:0] da, logic [W-1:0] db);
    {ab_le, ab_clk, ab_ce_n, ab_oe_n} = ab;
    {ba_le, ba_clk, ba_ce_n, ba_oe_n} = ba;
    a_in = da;
    b_in = db;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    a_in = 18'h3ffff; b_in = 18'h2aaaa;
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset cleared both stored words; hold mode exposes them
    chk("R9 b_o", b_out, '0);
    chk("R9 a_o", a_out, '0);

    // R6: transparent then falling latch enable keeps last word
    step(4'b1000, 4'b1000, 18'h12345, 18'h0abcd);
    step(4'b0000, 4'b0000, 18'h00001, 18'h00002);
    chk("R6 b_o", b_out, 18'h12345);
    chk("R6 R8 a_o", a_out, 18'h0abcd);
    // enabled edge replaces it
    step(4'b0100, 4'b0000, 18'h00777, 18'h00003);
    chk("R6 R3 b_o", b_out, 18'h00777);
    chk("R8 R6 a_o independent", a_out, 18'h0abcd);

    // R5: edges while transparent do not disturb tracking
    step(4'b1000, 4'b0000, 18'h11111, 18'h0);
    step(4'b1110, 4'b0000, 18'h22222, 18'h0);
    step(4'b0000, 4'b0000, 18'h33333, 18'h0);
    chk("R5 b_o", b_out, 18'h22222);

    // exhaustive ordered pairs of control codes, both directions
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        step(4'(p), 4'(15 - c), W'($urandom), W'($urandom));
        step(4'(c), 4'(p ^ 5), W'($urandom), W'($urandom));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule